// File: doc/BRIEF.md
# Burst-of-Two Quad-Rate SRAM Controller

This block is the host-side controller for a synchronous SRAM that has separate read and write data buses and moves two words per access. The user side has two independent request channels, one for reads and one for writes. Each takes one request per memory cycle, and one read and one write may be accepted in the same memory cycle. On the memory side the block drives a shared address bus that carries two addresses per memory cycle. The read address and the read select go out in the K beat. The write address goes out in the following K# beat. The write data and the active-low byte selects are driven double rate: word 0 in the K beat, word 1 in the K# beat.

The block is clocked by a fabric clock running at twice the memory clock. A phase register splits the fabric clock into alternating K and K# beats and brings that phase out as `mem_k`. A read is tracked by a tag that shifts along a chain as long as the read latency. The tag captures the two double-rate words returned on `mem_q` and hands them to the user as one wide word, with word 0 in the low half.

After reset the block holds both ready outputs low for an initialisation period. It then raises them and keeps them high. A handshake counts only in a fabric cycle where `user_tick` is high, which is one cycle in two. A request offered in any other cycle is left in place and is not consumed.

Top module: `qdr_b2_ctrl`

## Requirements
- R1: After reset is released, `rd_req_ready` and `wr_req_ready` stay low for INIT_CYCLES-1 clock edges. They go high at edge INIT_CYCLES and never fall again until the next reset.
- R2: After initialisation, `user_tick` is high on every second fabric cycle. A request transfers only when valid and ready are high in a tick cycle. A valid request offered outside a tick cycle and withdrawn before the next tick causes no memory access.
- R3: In the fabric cycle after an accepted read, the block drives a K beat (`mem_k`=1) with `mem_rps_n`=0 and `mem_addr` equal to the read address. A K beat with no accepted read has `mem_rps_n`=1.
- R4: In the K beat after an accepted write, `mem_wps_n`=0, `mem_d` is word 0 (`wr_req_data` bits W-1:0) and `mem_bws_n` is the inverse of `wr_req_mask` bits NB-1:0. In the next K# beat, `mem_addr` is the write address, `mem_d` is word 1 (upper half) and `mem_bws_n` is the inverse of the upper mask bits. A mask bit of 1 enables its byte lane; lane j is bits 9j+8:9j of a word.
- R5: `mem_k` alternates every fabric cycle. The port selects are never asserted (low) in a K# beat.
- R6: Each issued read yields exactly one `rd_resp_valid` pulse. The pulse comes RD_LAT_HALF+2 fabric cycles after the read's K beat cycle and carries {word 1, word 0} as captured from `mem_q` in cycles K+RD_LAT_HALF and K+RD_LAT_HALF+1.
- R7: A read and a write accepted in the same tick are both issued. A read of the address being written in that tick returns the contents from before the write.
- R8: Byte lanes whose mask bit is 0 keep their previous contents, as observed through a later read.
- R9: While reset is asserted, `mem_rps_n` and `mem_wps_n` are high, `rd_resp_valid` is low and both ready outputs are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fabric clock, twice the memory clock rate |
| rst_n | input | 1 | Asynchronous active-low reset |
| user_tick | output | 1 | Marks the fabric cycle in which handshakes count |
| rd_req_valid | input | 1 | Read request offered |
| rd_req_ready | output | 1 | Read channel can accept |
| rd_req_addr | input | AW (19) | Read address |
| wr_req_valid | input | 1 | Write request offered |
| wr_req_ready | output | 1 | Write channel can accept |
| wr_req_addr | input | AW (19) | Write address |
| wr_req_data | input | 2*W (36) | Both burst words, word 0 low |
| wr_req_mask | input | 2*NB (4) | Byte enables, active high, word 0 low |
| rd_resp_valid | output | 1 | One-cycle pulse per completed read |
| rd_resp_data | output | 2*W (36) | Read burst, word 0 low |
| mem_k | output | 1 | High in a K beat, low in a K# beat |
| mem_addr | output | AW (19) | Shared address bus |
| mem_rps_n | output | 1 | Read port select, active low |
| mem_wps_n | output | 1 | Write port select, active low |
| mem_bws_n | output | NB (2) | Byte write selects, active low |
| mem_d | output | W (18) | Double-rate write data |
| mem_q | input | W (18) | Double-rate read data |

## Verification
A read and a write can be accepted in the same tick, and their addresses then share one memory cycle on the address bus. The bench provokes this with directed same-address pairs and with random traffic over only eight addresses, so collisions are frequent. A behavioural memory model in the bench samples the read address in the K beat and commits the write one beat later. The bench computes every expected read word from its own reference array, updated in issue order with the read taken first. It compares the pins in both beats and each response's data and arrival cycle against those values.

// File: rtl/qdr_b2_pkg.sv
package qdr_b2_pkg;

  // fabric cycles from the read K beat to the response pulse
  function automatic int unsigned resp_delay(input int unsigned lat_half);
    return lat_half + 2;
  endfunction

  // width of a counter that must reach n
  function automatic int unsigned cnt_width(input int unsigned n);
    return (n < 2) ? 1 : $clog2(n + 1);
  endfunction

endpackage

// File: rtl/qdr_b2_init.sv
module qdr_b2_init #(
  parameter int unsigned INIT_CYCLES = 16
) (
  input  logic clk,
  input  logic rst_n,
  output logic init_done
);
  import qdr_b2_pkg::*;
  localparam int unsigned CW = cnt_width(INIT_CYCLES);
  localparam logic [CW-1:0] LAST = CW'(INIT_CYCLES - 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt       <= '0;
      init_done <= 1'b0;
    end else if (!init_done) begin
      cnt <= cnt + 1'b1;
      if (cnt == LAST) init_done <= 1'b1;
    end
  end
endmodule

// File: rtl/qdr_b2_issue.sv
module qdr_b2_issue #(
  parameter int unsigned AW = 19,
  parameter int unsigned W  = 18,
  parameter int unsigned NB = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            init_done,
  input  logic            rd_fire,
  input  logic [AW-1:0]   rd_addr,
  input  logic            wr_fire,
  input  logic [AW-1:0]   wr_addr,
  input  logic [2*W-1:0]  wr_data,
  input  logic [2*NB-1:0] wr_mask,
  output logic            user_tick,
  output logic            mem_k,
  output logic [AW-1:0]   mem_addr,
  output logic            mem_rps_n,
  output logic            mem_wps_n,
  output logic [NB-1:0]   mem_bws_n,
  output logic [W-1:0]    mem_d
);
  // second half of a write, held for the K# beat
  logic            st_v;
  logic [AW-1:0]   st_addr;
  logic [W-1:0]    st_d;
  logic [NB-1:0]   st_m;

  assign user_tick = init_done & ~mem_k;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mem_k     <= 1'b0;
      mem_addr  <= '0;
      mem_rps_n <= 1'b1;
      mem_wps_n <= 1'b1;
      mem_bws_n <= '1;
      mem_d     <= '0;
      st_v      <= 1'b0;
      st_addr   <= '0;
      st_d      <= '0;
      st_m      <= '0;
    end else begin
      mem_k <= ~mem_k;
      if (!mem_k) begin
        // building the K beat: read address, selects, word 0
        mem_addr  <= rd_fire ? rd_addr : '0;
        mem_rps_n <= ~rd_fire;
        mem_wps_n <= ~wr_fire;
        mem_d     <= wr_fire ? wr_data[W-1:0] : '0;
        mem_bws_n <= wr_fire ? ~wr_mask[NB-1:0] : '1;
        st_v      <= wr_fire;
        st_addr   <= wr_addr;
        st_d      <= wr_data[2*W-1:W];
        st_m      <= wr_mask[2*NB-1:NB];
      end else begin
        // building the K# beat: write address, word 1
        mem_addr  <= st_v ? st_addr : '0;
        mem_rps_n <= 1'b1;
        mem_wps_n <= 1'b1;
        mem_d     <= st_v ? st_d : '0;
        mem_bws_n <= st_v ? ~st_m : '1;
        st_v      <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/qdr_b2_rdpath.sv
module qdr_b2_rdpath #(
  parameter int unsigned W           = 18,
  parameter int unsigned RD_LAT_HALF = 3
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           rd_beat,
  input  logic [W-1:0]   mem_q,
  output logic           rd_resp_valid,
  output logic [2*W-1:0] rd_resp_data
);
  localparam int unsigned DEPTH = RD_LAT_HALF + 1;

  logic [DEPTH-1:0] tag;
  logic [W-1:0]     w0_q;
  logic             cap_w0;
  logic             cap_w1;

  assign cap_w0 = tag[RD_LAT_HALF-1];
  assign cap_w1 = tag[RD_LAT_HALF];

  generate
    if (DEPTH > 1) begin : g_chain
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) tag <= '0;
        else        tag <= {tag[DEPTH-2:0], rd_beat};
      end
    end else begin : g_one
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) tag <= '0;
        else        tag <= rd_beat;
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      w0_q          <= '0;
      rd_resp_valid <= 1'b0;
      rd_resp_data  <= '0;
    end else begin
      if (cap_w0) w0_q <= mem_q;
      rd_resp_valid <= cap_w1;
      if (cap_w1) rd_resp_data <= {mem_q, w0_q};
    end
  end
endmodule

// File: rtl/qdr_b2_ctrl.sv
module qdr_b2_ctrl #(
  parameter int unsigned AW          = 19,
  parameter int unsigned W           = 18,
  parameter int unsigned NB          = 2,
  parameter int unsigned RD_LAT_HALF = 3,
  parameter int unsigned INIT_CYCLES = 16
) (
  input  logic            clk,
  input  logic            rst_n,
  output logic            user_tick,
  input  logic            rd_req_valid,
  output logic            rd_req_ready,
  input  logic [AW-1:0]   rd_req_addr,
  input  logic            wr_req_valid,
  output logic            wr_req_ready,
  input  logic [AW-1:0]   wr_req_addr,
  input  logic [2*W-1:0]  wr_req_data,
  input  logic [2*NB-1:0] wr_req_mask,
  output logic            rd_resp_valid,
  output logic [2*W-1:0]  rd_resp_data,
  output logic            mem_k,
  output logic [AW-1:0]   mem_addr,
  output logic            mem_rps_n,
  output logic            mem_wps_n,
  output logic [NB-1:0]   mem_bws_n,
  output logic [W-1:0]    mem_d,
  input  logic [W-1:0]    mem_q
);
  logic init_done;
  logic rd_fire;
  logic wr_fire;
  logic rd_beat;

  assign rd_req_ready = init_done;
  assign wr_req_ready = init_done;
  assign rd_fire = rd_req_valid & rd_req_ready & user_tick;
  assign wr_fire = wr_req_valid & wr_req_ready & user_tick;
  assign rd_beat = mem_k & ~mem_rps_n;

  qdr_b2_init #(.INIT_CYCLES(INIT_CYCLES)) u_init (
    .clk(clk), .rst_n(rst_n), .init_done(init_done)
  );

  qdr_b2_issue #(.AW(AW), .W(W), .NB(NB)) u_issue (
    .clk(clk), .rst_n(rst_n), .init_done(init_done),
    .rd_fire(rd_fire), .rd_addr(rd_req_addr),
    .wr_fire(wr_fire), .wr_addr(wr_req_addr),
    .wr_data(wr_req_data), .wr_mask(wr_req_mask),
    .user_tick(user_tick), .mem_k(mem_k), .mem_addr(mem_addr),
    .mem_rps_n(mem_rps_n), .mem_wps_n(mem_wps_n),
    .mem_bws_n(mem_bws_n), .mem_d(mem_d)
  );

  qdr_b2_rdpath #(.W(W), .RD_LAT_HALF(RD_LAT_HALF)) u_rdpath (
    .clk(clk), .rst_n(rst_n), .rd_beat(rd_beat), .mem_q(mem_q),
    .rd_resp_valid(rd_resp_valid), .rd_resp_data(rd_resp_data)
  );
endmodule

// File: rtl/qdr_b2_ctrl_chk.sv
module qdr_b2_ctrl_chk #(
  parameter int unsigned AW = 19,
  parameter int unsigned W  = 18,
  parameter int unsigned NB = 2
) (
  input logic            clk,
  input logic            rst_n,
  input logic            user_tick,
  input logic            rd_req_ready,
  input logic [AW-1:0]   rd_req_addr,
  input logic [AW-1:0]   wr_req_addr,
  input logic [2*W-1:0]  wr_req_data,
  input logic [2*NB-1:0] wr_req_mask,
  input logic            rd_resp_valid,
  input logic            mem_k,
  input logic [AW-1:0]   mem_addr,
  input logic            mem_rps_n,
  input logic            mem_wps_n,
  input logic [NB-1:0]   mem_bws_n,
  input logic [W-1:0]    mem_d,
  input logic            rd_fire,
  input logic            wr_fire,
  input logic            rd_beat
);
  logic [7:0] outstanding;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) outstanding <= '0;
    else outstanding <= outstanding + {7'd0, rd_beat} - {7'd0, rd_resp_valid};
  end

  assert_ready_holds_R1: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req_ready |=> rd_req_ready);

  assert_tick_ready_R2: assert property (@(posedge clk) disable iff (!rst_n)
    user_tick |-> (rd_req_ready && !mem_k));

  assert_rd_issue_R3: assert property (@(posedge clk) disable iff (!rst_n)
    rd_fire |=> (mem_k && !mem_rps_n && mem_addr == $past(rd_req_addr)));

  assert_wr_word0_R4: assert property (@(posedge clk) disable iff (!rst_n)
    wr_fire |=> (!mem_wps_n && mem_d == $past(wr_req_data[W-1:0])
                 && mem_bws_n == ~$past(wr_req_mask[NB-1:0])));

  assert_wr_word1_R4: assert property (@(posedge clk) disable iff (!rst_n)
    wr_fire |=> ##1 (!mem_k && mem_addr == $past(wr_req_addr, 2)
                     && mem_d == $past(wr_req_data[2*W-1:W], 2)));

  assert_phase_toggle_R5: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (mem_k != $past(mem_k)));

  assert_sel_kbeat_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_k |-> (mem_rps_n && mem_wps_n));

  assert_resp_matched_R6: assert property (@(posedge clk) disable iff (!rst_n)
    rd_resp_valid |-> (outstanding != 8'd0));
endmodule

bind qdr_b2_ctrl qdr_b2_ctrl_chk #(.AW(AW), .W(W), .NB(NB)) u_chk (.*);

// File: tb/qdr_b2_ctrl_bench.sv
`timescale 1ns/1ps
module qdr_b2_ctrl_bench;
  localparam int AW = 19, W = 18, NB = 2, LAT = 3, INIT = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic user_tick, rd_req_ready, wr_req_ready, rd_resp_valid;
  logic rd_req_valid = 1'b0, wr_req_valid = 1'b0;
  logic [AW-1:0] rd_req_addr = '0, wr_req_addr = '0;
  logic [2*W-1:0] wr_req_data = '0;
  logic [2*NB-1:0] wr_req_mask = '0;
  logic [2*W-1:0] rd_resp_data;
  logic mem_k, mem_rps_n, mem_wps_n;
  logic [AW-1:0] mem_addr;
  logic [NB-1:0] mem_bws_n;
  logic [W-1:0] mem_d;
  logic [W-1:0] mem_q = '0;

  always #2 clk = ~clk;

  qdr_b2_ctrl #(.AW(AW), .W(W), .NB(NB), .RD_LAT_HALF(LAT), .INIT_CYCLES(INIT)) u_qdr_b2_ctrl (
    .clk(clk), .rst_n(rst_n), .user_tick(user_tick),
    .rd_req_valid(rd_req_valid), .rd_req_ready(rd_req_ready), .rd_req_addr(rd_req_addr),
    .wr_req_valid(wr_req_valid), .wr_req_ready(wr_req_ready), .wr_req_addr(wr_req_addr),
    .wr_req_data(wr_req_data), .wr_req_mask(wr_req_mask),
    .rd_resp_valid(rd_resp_valid), .rd_resp_data(rd_resp_data),
    .mem_k(mem_k), .mem_addr(mem_addr), .mem_rps_n(mem_rps_n), .mem_wps_n(mem_wps_n),
    .mem_bws_n(mem_bws_n), .mem_d(mem_d), .mem_q(mem_q)
  );

  int checks = 0, fails = 0, cyc = 0;

  // reference contents, updated in issue order
  logic [2*W-1:0] ref_mem [8];
  // behavioural device contents
  logic [W-1:0] dev0 [8];
  logic [W-1:0] dev1 [8];
  logic [W-1:0] qbuf [16];
  logic dp; logic [W-1:0] dd0; logic [NB-1:0] dm0;

  // expected responses
  logic [2*W-1:0] eq_data [64];
  int eq_cyc [64];
  int eq_wr = 0, eq_rd = 0;

  // pin expectations
  logic pk_v, pk_rd, pk_wr, pks_wr;
  logic [AW-1:0] pk_ra, pk_wa;
  logic [W-1:0] pk_w0, pk_w1;
  logic [NB-1:0] pk_m0, pk_m1;

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  function automatic logic [W-1:0] lane_merge(input logic [W-1:0] old_w, input logic [W-1:0] new_w,
                                              input logic [NB-1:0] en);
    logic [W-1:0] r;
    r = old_w;
    for (int j = 0; j < NB; j++)
      if (en[j]) r[j*9 +: 9] = new_w[j*9 +: 9];
    return r;
  endfunction

  task automatic step();
    @(negedge clk);
    cyc++;
    // responses (R6)
    if (rd_resp_valid) begin
      if (eq_rd == eq_wr) chk(0, "R6 unexpected response", 64'(rd_resp_data), 64'd0);
      else begin
        chk(rd_resp_data == eq_data[eq_rd % 64], "R6/R7/R8 read data",
            64'(rd_resp_data), 64'(eq_data[eq_rd % 64]));
        chk(cyc == eq_cyc[eq_rd % 64], "R6 response cycle", 64'(cyc), 64'(eq_cyc[eq_rd % 64]));
        eq_rd++;
      end
    end
    // pins
    if (mem_k && pk_v) begin
      chk(mem_rps_n == !pk_rd, "R3 read select", 64'(mem_rps_n), 64'(!pk_rd));
      if (pk_rd) chk(mem_addr == pk_ra, "R3 read address", 64'(mem_addr), 64'(pk_ra));
      chk(mem_wps_n == !pk_wr, "R4 write select", 64'(mem_wps_n), 64'(!pk_wr));
      if (pk_wr) begin
        chk(mem_d == pk_w0, "R4 word0", 64'(mem_d), 64'(pk_w0));
        chk(mem_bws_n == ~pk_m0, "R4 mask0", 64'(mem_bws_n), 64'(~pk_m0));
      end
      pks_wr = pk_wr; pk_v = 0;
    end else if (!mem_k && pks_wr) begin
      chk(mem_addr == pk_wa && mem_d == pk_w1 && mem_bws_n == ~pk_m1, "R4 K# beat",
          {mem_addr, mem_bws_n, mem_d}, {pk_wa, ~pk_m1, pk_w1});
      pks_wr = 0;
    end
    if (!mem_k && rst_n)
      chk(mem_rps_n && mem_wps_n, "R5 no select in K# beat", 64'({mem_rps_n, mem_wps_n}), 64'd3);
    // device model
    if (mem_k && !mem_rps_n) begin
      qbuf[(cyc + LAT) % 16]     = dev0[mem_addr[2:0]];
      qbuf[(cyc + LAT + 1) % 16] = dev1[mem_addr[2:0]];
    end
    if (!mem_k && dp) begin
      dev0[mem_addr[2:0]] = lane_merge(dev0[mem_addr[2:0]], dd0, dm0);
      dev1[mem_addr[2:0]] = lane_merge(dev1[mem_addr[2:0]], mem_d, ~mem_bws_n);
      dp = 0;
    end
    if (mem_k && !mem_wps_n) begin
      dp = 1; dd0 = mem_d; dm0 = ~mem_bws_n;
    end
    mem_q = qbuf[cyc % 16];
  endtask

  task automatic do_tick(input bit rd, input logic [2:0] ra, input bit wr, input logic [2:0] wa,
                         input logic [2*W-1:0] wd, input logic [2*NB-1:0] wm);
    while (!user_tick) step();
    rd_req_valid = rd; rd_req_addr = AW'(ra);
    wr_req_valid = wr; wr_req_addr = AW'(wa);
    wr_req_data = wd; wr_req_mask = wm;
    pk_v = 1; pk_rd = rd; pk_ra = AW'(ra); pk_wr = wr; pk_wa = AW'(wa);
    pk_w0 = wd[W-1:0]; pk_w1 = wd[2*W-1:W]; pk_m0 = wm[NB-1:0]; pk_m1 = wm[2*NB-1:NB];
    if (rd) begin  // read sees contents before this tick's write (R7)
      eq_data[eq_wr % 64] = ref_mem[ra];
      eq_cyc[eq_wr % 64] = cyc + 1 + LAT + 2;
      eq_wr++;
    end
    if (wr) begin
      ref_mem[wa][W-1:0]   = lane_merge(ref_mem[wa][W-1:0], wd[W-1:0], wm[NB-1:0]);
      ref_mem[wa][2*W-1:W] = lane_merge(ref_mem[wa][2*W-1:W], wd[2*W-1:W], wm[2*NB-1:NB]);
    end
    step();
    rd_req_valid = 0; wr_req_valid = 0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    int seed;
    seed = $urandom(32'd1234);
    pk_v = 0; pks_wr = 0; dp = 0;
    for (int i = 0; i < 8; i++) begin ref_mem[i] = '0; dev0[i] = '0; dev1[i] = '0; end
    for (int i = 0; i < 16; i++) qbuf[i] = '0;
    repeat (3) step();
    // R9 reset state
    chk(mem_rps_n && mem_wps_n && !rd_resp_valid && !rd_req_ready && !wr_req_ready,
        "R9 reset outputs", 64'({mem_rps_n, mem_wps_n, rd_resp_valid, rd_req_ready, wr_req_ready}), 64'b11000);
    rst_n = 1;
    repeat (INIT - 1) step();
    chk(!rd_req_ready && !wr_req_ready, "R1 ready low in init", 64'({rd_req_ready, wr_req_ready}), 64'd0);
    step();
    chk(rd_req_ready && wr_req_ready, "R1 ready after init", 64'({rd_req_ready, wr_req_ready}), 64'd3);
    // R2 tick every second cycle
    begin
      int t = 0;
      for (int i = 0; i < 8; i++) begin step(); t += int'(user_tick); end
      chk(t == 4, "R2 tick rate", 64'(t), 64'd4);
    end
    // fill all addresses, full mask (R4)
    for (int i = 0; i < 8; i++)
      do_tick(0, 0, 1, 3'(i), {18'(i * 1111 + 5), 18'(i * 777 + 3)}, 4'hF);
    // read them back (R3, R6)
    for (int i = 0; i < 8; i++) do_tick(1, 3'(i), 0, 0, '0, '0);
    // same address read and write in one tick: old data (R7)
    do_tick(1, 3'd3, 1, 3'd3, {18'h2AAAA, 18'h15555}, 4'hF);
    do_tick(1, 3'd3, 0, 0, '0, '0);
    // byte masking (R8)
    do_tick(0, 0, 1, 3'd5, {18'h3FFFF, 18'h3FFFF}, 4'b1001);
    do_tick(0, 0, 1, 3'd6, {18'h00000, 18'h00000}, 4'b0000);
    do_tick(1, 3'd5, 1, 3'd5, {18'h12345, 18'h0ABCD}, 4'b0110);
    do_tick(1, 3'd5, 0, 0, '0, '0);
    do_tick(1, 3'd6, 0, 0, '0, '0);
    // request offered off-tick and withdrawn (R2)
    while (user_tick) step();
    rd_req_valid = 1; rd_req_addr = AW'(7);
    step();
    rd_req_valid = 0;
    step();
    chk(mem_k && mem_rps_n, "R2 off-tick request ignored", 64'({mem_k, mem_rps_n}), 64'd3);
    // random traffic
    for (int n = 0; n < 400; n++)
      do_tick(1'($urandom), 3'($urandom), 1'($urandom), 3'($urandom),
              {18'($urandom), 18'($urandom)}, 4'($urandom));
    repeat (20) step();
    chk(eq_rd == eq_wr, "R6 every read answered", 64'(eq_rd), 64'(eq_wr));
    chk(rd_req_ready && wr_req_ready, "R1 ready held", 64'({rd_req_ready, wr_req_ready}), 64'd3);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule